// File: doc/BRIEF.md
# Asynchronous Scanline-Tripling Upscaler

This block is the output half of a video capture path. Its input is a single frame buffer that another clock domain fills with source pixels. The block reads that buffer from its own free-running output pixel clock and produces a complete raster with horizontal sync, vertical sync and a data-enable strobe, ready to feed a TMDS encoder. It takes no lock to the source side. When a write and a read cross within the same frame, a tear line is accepted as normal behaviour.

Two output formats can be selected: 1024x768 (XGA, 65.0 MHz pixel clock) and 1280x720. Vertically, every source row is shown on three consecutive output lines. Horizontally, each source pixel is repeated by the dot-clock divider the source used (4, 3 or 2), so every source mode fills roughly the same 1024 output columns.

- In 1280x720, the image is centred horizontally and the side columns are black.
- Only 240 of the 256 source rows fit in 720 lines. The shown rows are centred, so 8 rows are skipped at the top.

The divider code arrives from the other clock domain. It is synchronized here and takes effect only during vertical blanking. The format select takes effect at the frame boundary.

Top module: `scan_tripler`

## Requirements
- R1: While reset is asserted, and on the first two cycles after it is released, de_o, hsync_o and vsync_o are 0 and pix_o is 0. Reset starts the raster at column 0, line 0, with divider factor 4 and the format taken from fmt_sel.
- R2: The raster follows these timings. Each line has active, front porch, sync and back porch columns in that order; each frame has active, front porch, sync and back porch lines in that order.
  - XGA: 1024/24/136/160 columns and 768/3/6/29 lines.
  - HD: 1280/110/40/220 columns and 720/5/5/20 lines.
  - de_o is 1 exactly on active columns of active lines.
- R3: hsync_o is 1 (positive polarity) over the horizontal sync columns on every line. vsync_o is 1 over every column of the vertical sync lines.
- R4: div_code 2'b00 gives a horizontal repeat of 4, 2'b01 a repeat of 3, and 2'b10 or 2'b11 a repeat of 2. Let x be the output column minus the horizontal offset and r the repeat. Then:
  - The source column is x/r.
  - Columns from r*floor(1024/r) up to 1024 are black (pix_o = 0).
- R5: Each source row covers three consecutive output lines. The source row is line/3 plus the vertical offset.
- R6: In XGA (fmt_sel = 0) both offsets are 0. In HD (fmt_sel = 1), the horizontal offset is 128 columns and the vertical offset is 8 source rows. Active columns outside the scaled image are black.
- R7: A new div_code is synchronized through two flops. It takes effect at the first line of vertical blanking. Any frame already being scanned keeps its factor.
- R8: A new fmt_sel takes effect only at the start of the next frame, at column 0 of line 0.
- R9: The frame buffer is addressed with fb_rd_en, fb_rd_row and fb_rd_col one cycle before the matching pixel. The buffer returns the data one cycle after the address.
  - pix_o shows fb_rd_data on image pixels and 0 everywhere else.
  - de_o is 1 on the cycle after every cycle in which fb_rd_en is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 1 | Output format: 0 = 1024x768, 1 = 1280x720 |
| div_code | input | 2 | Source dot-clock divider code, from the capture clock domain |
| fb_rd_en | output | 1 | Frame buffer read enable |
| fb_rd_row | output | 8 | Source row to read |
| fb_rd_col | output | 9 | Source column to read |
| fb_rd_data | input | 9 | Frame buffer read data, one cycle after the address |
| de_o | output | 1 | Data enable |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| pix_o | output | 9 | Output pixel value, 0 outside the image |

## Verification
The bench scales the timings down and steps a model of the raster through every divider code in both formats.

- **Remainder columns:** these occur when 1024 is not a multiple of 3. A design that kept reading past r*floor(1024/r) would show a stray partial source pixel instead of black.
- **Centring:** the centring offsets are checked at both edges of the image. An off-by-one offset shifts every pixel of the frame against the model.
- **Mid-frame divider and format changes:** both are driven in the middle of the active region. A design that applied them at once would tear the frame in progress, and a design that ignored them would keep the old mode on the next frame.
- **Reset mid-frame:** a reset in the middle of a frame must restart the raster at column 0 with quiet outputs.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        DIV4  = 2'b00,
        DIV3  = 2'b01,
        DIV2  = 2'b10,
        DIV2X = 2'b11
    } div_e;

    typedef enum logic {
        FMT_XGA = 1'b0,
        FMT_HD  = 1'b1
    } fmt_e;

    typedef struct packed {
        logic active;
        logic hs;
        logic vs;
    } sync_t;

    function automatic int rep_of(div_e d);
        int r;
        unique case (d)
            DIV4:    r = 4;
            DIV3:    r = 3;
            default: r = 2;
        endcase
        return r;
    endfunction

    // Output columns actually covered by whole repeated source pixels
    function automatic int span_of(div_e d, int width);
        return rep_of(d) * (width / rep_of(d));
    endfunction

endpackage

// File: rtl/scan_timing.sv
module scan_timing
    import scan_pkg::*;
#(
    parameter int H_ACT_A = 1024, parameter int H_FP_A = 24,  parameter int H_SY_A = 136, parameter int H_BP_A = 160,
    parameter int V_ACT_A = 768,  parameter int V_FP_A = 3,   parameter int V_SY_A = 6,   parameter int V_BP_A = 29,
    parameter int H_ACT_B = 1280, parameter int H_FP_B = 110, parameter int H_SY_B = 40,  parameter int H_BP_B = 220,
    parameter int V_ACT_B = 720,  parameter int V_FP_B = 5,   parameter int V_SY_B = 5,   parameter int V_BP_B = 20,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fmt_sel,
    output logic [CW-1:0] h_cnt,
    output logic [CW-1:0] v_cnt,
    output fmt_e          fmt_q,
    output sync_t         raster,
    output logic          blank_start,
    output logic [CW-1:0] v_act_cur
);
    localparam logic [CW-1:0] HT_A = CW'(H_ACT_A + H_FP_A + H_SY_A + H_BP_A - 1);
    localparam logic [CW-1:0] VT_A = CW'(V_ACT_A + V_FP_A + V_SY_A + V_BP_A - 1);
    localparam logic [CW-1:0] HT_B = CW'(H_ACT_B + H_FP_B + H_SY_B + H_BP_B - 1);
    localparam logic [CW-1:0] VT_B = CW'(V_ACT_B + V_FP_B + V_SY_B + V_BP_B - 1);

    logic [CW-1:0] h_last, v_last, h_act, hs_lo, hs_hi, vs_lo, vs_hi;

    always_comb begin
        if (fmt_q == FMT_HD) begin
            h_last    = HT_B;
            v_last    = VT_B;
            h_act     = CW'(H_ACT_B);
            v_act_cur = CW'(V_ACT_B);
            hs_lo     = CW'(H_ACT_B + H_FP_B);
            hs_hi     = CW'(H_ACT_B + H_FP_B + H_SY_B);
            vs_lo     = CW'(V_ACT_B + V_FP_B);
            vs_hi     = CW'(V_ACT_B + V_FP_B + V_SY_B);
        end else begin
            h_last    = HT_A;
            v_last    = VT_A;
            h_act     = CW'(H_ACT_A);
            v_act_cur = CW'(V_ACT_A);
            hs_lo     = CW'(H_ACT_A + H_FP_A);
            hs_hi     = CW'(H_ACT_A + H_FP_A + H_SY_A);
            vs_lo     = CW'(V_ACT_A + V_FP_A);
            vs_hi     = CW'(V_ACT_A + V_FP_A + V_SY_A);
        end
        raster.active = (h_cnt < h_act) && (v_cnt < v_act_cur);
        raster.hs     = (h_cnt >= hs_lo) && (h_cnt < hs_hi);
        raster.vs     = (v_cnt >= vs_lo) && (v_cnt < vs_hi);
        blank_start   = (h_cnt == '0) && (v_cnt == v_act_cur);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt <= '0;
            v_cnt <= '0;
            fmt_q <= fmt_e'(fmt_sel);
        end else if (h_cnt == h_last) begin
            h_cnt <= '0;
            if (v_cnt == v_last) begin
                v_cnt <= '0;
                fmt_q <= fmt_e'(fmt_sel);
            end else begin
                v_cnt <= v_cnt + 1'b1;
            end
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    // R8
    fmt_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fmt_q) |-> (h_cnt == '0 && v_cnt == '0));

endmodule

// File: rtl/scan_mode_sync.sv
module scan_mode_sync
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_async,
    input  logic       load,
    output div_e       div_q
);
    logic [1:0] meta_q, safe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 2'b00;
            safe_q <= 2'b00;
            div_q  <= DIV4;
        end else begin
            meta_q <= div_async;
            safe_q <= meta_q;
            if (load) div_q <= div_e'(safe_q);
        end
    end
endmodule

// File: rtl/scan_addr_map.sv
module scan_addr_map
    import scan_pkg::*;
#(
    parameter int H_ACT_A = 1024,
    parameter int H_ACT_B = 1280,
    parameter int V_ACT_A = 768,
    parameter int V_ACT_B = 720,
    parameter int CW      = 11,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 9
) (
    input  logic [CW-1:0]    h_cnt,
    input  logic [CW-1:0]    v_cnt,
    input  fmt_e             fmt,
    input  div_e             div,
    output logic             img,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    localparam int            SRC_ROWS = V_ACT_A / 3;
    localparam logic [CW-1:0] HOFF_B   = CW'((H_ACT_B - H_ACT_A) / 2);
    localparam logic [CW-1:0] VOFF_B   = CW'((SRC_ROWS - V_ACT_B / 3) / 2);

    logic [CW-1:0] hoff, voff, vact, x, span, col_full, row_full;

    always_comb begin
        hoff = (fmt == FMT_HD) ? HOFF_B : '0;
        voff = (fmt == FMT_HD) ? VOFF_B : '0;
        vact = (fmt == FMT_HD) ? CW'(V_ACT_B) : CW'(V_ACT_A);
        x    = h_cnt - hoff;
        span = CW'(span_of(div, H_ACT_A));
        img  = (h_cnt >= hoff) && (x < span) && (v_cnt < vact);
        unique case (div)
            DIV4:    col_full = x >> 2;
            DIV3:    col_full = x / CW'(3);
            default: col_full = x >> 1;
        endcase
        row_full = v_cnt / CW'(3) + voff;
        row = row_full[ROW_W-1:0];
        col = col_full[COL_W-1:0];
    end
endmodule

// File: rtl/scan_tripler.sv
module scan_tripler
    import scan_pkg::*;
#(
    parameter int PIX_W   = 9,
    parameter int H_ACT_A = 1024, parameter int H_FP_A = 24,  parameter int H_SY_A = 136, parameter int H_BP_A = 160,
    parameter int V_ACT_A = 768,  parameter int V_FP_A = 3,   parameter int V_SY_A = 6,   parameter int V_BP_A = 29,
    parameter int H_ACT_B = 1280, parameter int H_FP_B = 110, parameter int H_SY_B = 40,  parameter int H_BP_B = 220,
    parameter int V_ACT_B = 720,  parameter int V_FP_B = 5,   parameter int V_SY_B = 5,   parameter int V_BP_B = 20,
    localparam int HT_A   = H_ACT_A + H_FP_A + H_SY_A + H_BP_A,
    localparam int HT_B   = H_ACT_B + H_FP_B + H_SY_B + H_BP_B,
    localparam int VT_A   = V_ACT_A + V_FP_A + V_SY_A + V_BP_A,
    localparam int VT_B   = V_ACT_B + V_FP_B + V_SY_B + V_BP_B,
    localparam int MAX_H  = (HT_A > HT_B) ? HT_A : HT_B,
    localparam int MAX_V  = (VT_A > VT_B) ? VT_A : VT_B,
    localparam int CW     = $clog2(((MAX_H > MAX_V) ? MAX_H : MAX_V) + 1),
    localparam int ROW_W  = $clog2(V_ACT_A / 3),
    localparam int COL_W  = $clog2(H_ACT_A / 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fmt_sel,
    input  logic [1:0]       div_code,
    output logic             fb_rd_en,
    output logic [ROW_W-1:0] fb_rd_row,
    output logic [COL_W-1:0] fb_rd_col,
    input  logic [PIX_W-1:0] fb_rd_data,
    output logic             de_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic [PIX_W-1:0] pix_o
);
    logic [CW-1:0]    h_cnt, v_cnt, v_act_cur;
    fmt_e             fmt_q;
    div_e             div_q;
    sync_t            raster, st1_q, st2_q;
    logic             blank_start, img;
    logic             img2_q;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;

    scan_timing #(
        .H_ACT_A(H_ACT_A), .H_FP_A(H_FP_A), .H_SY_A(H_SY_A), .H_BP_A(H_BP_A),
        .V_ACT_A(V_ACT_A), .V_FP_A(V_FP_A), .V_SY_A(V_SY_A), .V_BP_A(V_BP_A),
        .H_ACT_B(H_ACT_B), .H_FP_B(H_FP_B), .H_SY_B(H_SY_B), .H_BP_B(H_BP_B),
        .V_ACT_B(V_ACT_B), .V_FP_B(V_FP_B), .V_SY_B(V_SY_B), .V_BP_B(V_BP_B),
        .CW(CW)
    ) timing_i (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .fmt_q(fmt_q), .raster(raster),
        .blank_start(blank_start), .v_act_cur(v_act_cur)
    );

    scan_mode_sync mode_i (
        .clk(clk), .rst(rst), .div_async(div_code), .load(blank_start), .div_q(div_q)
    );

    scan_addr_map #(
        .H_ACT_A(H_ACT_A), .H_ACT_B(H_ACT_B), .V_ACT_A(V_ACT_A), .V_ACT_B(V_ACT_B),
        .CW(CW), .ROW_W(ROW_W), .COL_W(COL_W)
    ) map_i (
        .h_cnt(h_cnt), .v_cnt(v_cnt), .fmt(fmt_q), .div(div_q),
        .img(img), .row(row), .col(col)
    );

    // Stage 1: address to frame buffer, sync pipeline alongside
    always_ff @(posedge clk) begin
        if (rst) begin
            fb_rd_en  <= 1'b0;
            fb_rd_row <= '0;
            fb_rd_col <= '0;
            st1_q     <= '0;
        end else begin
            fb_rd_en  <= img;
            fb_rd_row <= row;
            fb_rd_col <= col;
            st1_q     <= raster;
        end
    end

    // Stage 2: aligned with the registered read data
    always_ff @(posedge clk) begin
        if (rst) begin
            st2_q  <= '0;
            img2_q <= 1'b0;
        end else begin
            st2_q  <= st1_q;
            img2_q <= fb_rd_en;
        end
    end

    assign de_o    = st2_q.active;
    assign hsync_o = st2_q.hs;
    assign vsync_o = st2_q.vs;
    assign pix_o   = img2_q ? fb_rd_data : '0;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!de_o && !hsync_o && !vsync_o));

    // R2
    de_outside_sync_chk: assert property (@(posedge clk) disable iff (rst)
        de_o |-> (!hsync_o && !vsync_o));

    // R9
    read_leads_de_chk: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |=> de_o);

    // R4
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_rd_en && $past(fb_rd_en)) |->
            (fb_rd_col == $past(fb_rd_col) || fb_rd_col == COL_W'($past(fb_rd_col) + 1'b1)));

    // R7
    div_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_q) |-> (v_cnt >= v_act_cur));

endmodule

// File: tb/scan_tripler_tb_top.sv
`timescale 1ns/1ps
module scan_tripler_tb_top;
    localparam int PIX_W = 9;
    localparam int HA = 26, HFA = 2, HSA = 3, HBA = 3;
    localparam int VA = 18, VFA = 1, VSA = 2, VBA = 2;
    localparam int HB = 34, HFB = 2, HSB = 3, HBB = 3;
    localparam int VB = 12, VFB = 1, VSB = 2, VBB = 2;
    localparam int ROW_W = $clog2(VA / 3);
    localparam int COL_W = $clog2(HA / 2);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst = 1'b1;
    logic             fmt_in = 1'b0;
    logic [1:0]       div_in = 2'b00;
    logic             fb_rd_en;
    logic [ROW_W-1:0] fb_rd_row;
    logic [COL_W-1:0] fb_rd_col;
    logic [PIX_W-1:0] fb_data = '0;
    logic             de_o, hsync_o, vsync_o;
    logic [PIX_W-1:0] pix_o;

    scan_tripler #(
        .PIX_W(PIX_W),
        .H_ACT_A(HA), .H_FP_A(HFA), .H_SY_A(HSA), .H_BP_A(HBA),
        .V_ACT_A(VA), .V_FP_A(VFA), .V_SY_A(VSA), .V_BP_A(VBA),
        .H_ACT_B(HB), .H_FP_B(HFB), .H_SY_B(HSB), .H_BP_B(HBB),
        .V_ACT_B(VB), .V_FP_B(VFB), .V_SY_B(VSB), .V_BP_B(VBB)
    ) dut_i (
        .clk(clk), .rst(rst), .fmt_sel(fmt_in), .div_code(div_in),
        .fb_rd_en(fb_rd_en), .fb_rd_row(fb_rd_row), .fb_rd_col(fb_rd_col),
        .fb_rd_data(fb_data), .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .pix_o(pix_o)
    );

    function automatic int hsh(int r, int c);
        return (r * 37 + c * 11 + 5 + (r << 4)) % 512;
    endfunction

    // Frame buffer model: registered read
    always @(posedge clk) begin
        if (fb_rd_en) fb_data <= PIX_W'(hsh(int'(fb_rd_row), int'(fb_rd_col)));
        else          fb_data <= '0;
    end

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
        logic img;
        int   pix;
    } exp_t;

    function automatic exp_t model(int h, int v, int fmt, int dv);
        exp_t e;
        int hact, vact, hfp, hsy, vfp, vsy, hoff, voff, fac, span, x;
        hact = fmt ? HB : HA;   vact = fmt ? VB : VA;
        hfp  = fmt ? HFB : HFA; hsy  = fmt ? HSB : HSA;
        vfp  = fmt ? VFB : VFA; vsy  = fmt ? VSB : VSA;
        hoff = fmt ? (HB - HA) / 2 : 0;
        voff = fmt ? (VA / 3 - VB / 3) / 2 : 0;
        fac  = (dv == 0) ? 4 : (dv == 1) ? 3 : 2;
        span = fac * (HA / fac);
        x    = h - hoff;
        e.de  = (h < hact) && (v < vact);
        e.hs  = (h >= hact + hfp) && (h < hact + hfp + hsy);
        e.vs  = (v >= vact + vfp) && (v < vact + vfp + vsy);
        e.img = e.de && (h >= hoff) && (x < span);
        e.pix = e.img ? hsh(v / 3 + voff, x / fac) : 0;
        return e;
    endfunction

    int checks = 0;
    int fails  = 0;
    int mh = 0, mv = 0, mfmt = 0, mdiv = 0;
    int rst_edges = 0, post_edges = 0;
    bit en_prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at h=%0d v=%0d: actual=%0d expected=%0d", tag, what, mh, mv, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin rst_edges++; post_edges = 0; end
        else begin rst_edges = 0; if (post_edges < 3) post_edges++; end
    end

    always @(negedge clk) begin
        exp_t e;
        int htot, vtot, vact;
        if (rst) begin
            mh = 0; mv = 0; mfmt = int'(fmt_in); mdiv = 0; en_prev = 1'b0;
            if (rst_edges >= 1) begin
                // R1
                chk(!de_o && !hsync_o && !vsync_o, "R1", "sync quiet in reset",
                    int'({de_o, hsync_o, vsync_o}), 0);
                chk(pix_o == '0, "R1", "pixel zero in reset", int'(pix_o), 0);
            end
        end else if (post_edges >= 2) begin
            e = model(mh, mv, mfmt, mdiv);
            chk(de_o == e.de, (int'(fmt_in) != mfmt) ? "R8" : "R2", "de", int'(de_o), int'(e.de));
            chk(hsync_o == e.hs, "R3", "hsync", int'(hsync_o), int'(e.hs));
            chk(vsync_o == e.vs, "R3", "vsync", int'(vsync_o), int'(e.vs));
            if (int'(div_in) != mdiv && e.img)
                chk(int'(pix_o) == e.pix, "R7", "pixel with pending divider", int'(pix_o), e.pix);
            else if (mfmt == 1)
                chk(int'(pix_o) == e.pix, "R6", "pixel in HD", int'(pix_o), e.pix);
            else
                chk(int'(pix_o) == e.pix, "R4/R5", "pixel in XGA", int'(pix_o), e.pix);
            if (en_prev)
                chk(de_o == 1'b1, "R9", "de after read", int'(de_o), 1);
            en_prev = fb_rd_en;
            htot = mfmt ? HB + HFB + HSB + HBB : HA + HFA + HSA + HBA;
            vtot = mfmt ? VB + VFB + VSB + VBB : VA + VFA + VSA + VBA;
            vact = mfmt ? VB : VA;
            if (mh == htot - 1) begin
                mh = 0;
                if (mv == vtot - 1) begin mv = 0; mfmt = int'(fmt_in); end
                else begin mv++; if (mv == vact) mdiv = int'(div_in); end
            end else mh++;
        end else begin
            en_prev = fb_rd_en;
        end
    end

    task automatic mid_frame();
        int target;
        target = (mfmt ? VB : VA) / 2;
        do @(negedge clk); while (!(mv == target && mh == 1));
    endtask

    task automatic run_frames(input int n);
        for (int i = 0; i < n; i++) mid_frame();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20151116);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        run_frames(2);
        // Directed: every divider code in XGA, then in HD (R4, R6, R7, R8)
        for (int f = 0; f < 2; f++) begin
            for (int d = 0; d < 4; d++) begin
                mid_frame();
                div_in = 2'(d);
                fmt_in = f[0];
                run_frames(2);
            end
        end
        // Random mode mix
        for (int k = 0; k < 8; k++) begin
            mid_frame();
            div_in = 2'($urandom % 4);
            fmt_in = 1'($urandom % 2);
            run_frames(1 + int'($urandom % 2));
        end
        // Reset in the middle of a frame (R1)
        mid_frame();
        repeat (5) @(negedge clk);
        rst = 1'b1;
        fmt_in = 1'b0;
        div_in = 2'b01;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run_frames(2);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        summary();
    end
endmodule